// File: doc/BRIEF.md
# Grouped Event Interrupt Aggregator

This block gathers one-cycle event pulses from many peripherals into three 32-bit sticky pending words. Each pending word is gated by three mask words, one per interrupt line. The three gated results drive three level interrupt outputs. Line A is wired to the CPU's most urgent level of the three (13), line B to level 11 and line C to level 9.

A peripheral reports an event by strobing `evt_valid` with a 7-bit `evt_code`. The two upper code bits choose the group and the five lower bits choose the bit inside that group. Software inspects and services the block through a small word-addressed register port. Pending words are write-one-to-clear, and mask words are plain read/write storage.

The block holds no sequencer. All of its state is the three pending words and the nine mask words. Each interrupt line is a combinational OR over the groups of pending AND mask, so a mask edit changes the line on the cycle after the write.

Top module: `evt_irq_hub`

## Requirements
- R1: An event with `evt_valid` high and code bits [6:5] equal to g (0, 1 or 2) sets bit `evt_code[4:0]` of pending word g at the next rising clock edge.
- R2: A pending bit stays set until software clears it. Events on other bits and mask writes leave it unchanged.
- R3: A write to pending offset g (g = 0, 1, 2) clears exactly the bits of word g whose write-data bits are 1. Bits written as 0 keep their value.
- R4: If an event and a software clear target the same pending bit in the same cycle, the bit is set after the edge.
- R5: An event whose code bits [6:5] equal 3 changes no pending word.
- R6: Register offsets are 0–2 for pending words of groups 0–2, 4–6 for A masks, 8–10 for B masks and 12–14 for C masks. Mask words read back the last value written, and a mask write does not alter pending state.
- R7: `irq_a` is high exactly when some group g has a bit set in both pending word g and A mask g. `irq_b` and `irq_c` follow the same rule with the B and C masks.
- R8: A change of a mask or a pending clear is reflected on the interrupt lines in the cycle after the write, with no new event. A line drops only when its AND of pending and mask is zero for all three groups.
- R9: Offsets 3, 7, 11 and 15 read as zero, and writes to them change no register.
- R10: While reset is low and after it, all pending and mask words are zero and all three interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event strobe, one event per cycle |
| evt_code | input | 7 | Event code: [6:5] group, [4:0] bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_a | output | 1 | Interrupt line A, to CPU level 13 |
| irq_b | output | 1 | Interrupt line B, to CPU level 11 |
| irq_c | output | 1 | Interrupt line C, to CPU level 9 |

## Verification
The bound checker watches four things on every cycle. A decoded event must land in its pending bit even when it collides with a clear. A cleared pending word must hold none of the written ones unless an event refills it. Pending state must stay frozen on idle cycles and on group-3 codes. The lines must be low whenever nothing is pending, and an A-mask write that overlaps pending bits must raise `irq_a` on the next cycle. Only the bench's scenarios can show the readback of every mapped offset and the zero read and ignored writes at unmapped offsets. The same holds for the exact mix of A, B and C lines as masks and clears are applied in sequence, and for the full return to zero after a reset in mid-run.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    // Register banks selected by reg_addr[3:2]; the order is decoded by the top.
    typedef enum logic [1:0] {
        BANK_PEND   = 2'd0,
        BANK_MASK_A = 2'd1,
        BANK_MASK_B = 2'd2,
        BANK_MASK_C = 2'd3
    } bank_e;

    // Number of interrupt lines, one mask bank each (A, B, C).
    localparam int IRQ_LINES = 3;

    // Width of the group field at the top of an event code.
    localparam int GRP_FIELD_W = 2;

endpackage

// File: rtl/evt_code_decode.sv
module evt_code_decode #(
    parameter int GROUPS = 3,
    parameter int DATA_W = 32,
    localparam int BIT_W  = $clog2(DATA_W),
    localparam int CODE_W = BIT_W + evt_irq_pkg::GRP_FIELD_W
) (
    input  logic                           evt_valid,
    input  logic [CODE_W-1:0]              evt_code,
    output logic [GROUPS-1:0][DATA_W-1:0]  set_vec
);

    logic [evt_irq_pkg::GRP_FIELD_W-1:0] grp_field;
    logic [BIT_W-1:0]                    bit_field;

    assign grp_field = evt_code[CODE_W-1 -: evt_irq_pkg::GRP_FIELD_W];
    assign bit_field = evt_code[BIT_W-1:0];

    // One-hot set vector; a group field beyond GROUPS-1 matches nothing.
    always_comb begin
        set_vec = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (evt_valid && (int'(grp_field) == g)) begin
                set_vec[g][bit_field] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/evt_pend_word.sv
module evt_pend_word #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_bits,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] clr_bits,
    output logic [DATA_W-1:0] pend
);

    logic [DATA_W-1:0] clr_mask;
    logic [DATA_W-1:0] pend_nxt;

    // Clear first, then OR in new events so a colliding event survives.
    always_comb begin
        clr_mask = clr_en ? clr_bits : '0;
        pend_nxt = (pend & ~clr_mask) | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= pend_nxt;
        end
    end

endmodule

// File: rtl/evt_mask_word.sv
module evt_mask_word #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (wr_en) begin
            mask <= wdata;
        end
    end

endmodule

// File: rtl/evt_irq_reduce.sv
module evt_irq_reduce #(
    parameter int GROUPS = 3,
    parameter int DATA_W = 32,
    parameter int LINES  = evt_irq_pkg::IRQ_LINES
) (
    input  logic [GROUPS-1:0][DATA_W-1:0]             pend,
    input  logic [LINES-1:0][GROUPS-1:0][DATA_W-1:0]  masks,
    output logic [LINES-1:0]                          irq
);

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int g = 0; g < GROUPS; g++) begin
                hit = hit | (|(pend[g] & masks[l][g]));
            end
        end
        assign irq[l] = hit;
    end

endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub #(
    parameter int GROUPS = 3,
    parameter int DATA_W = 32,
    localparam int BIT_W  = $clog2(DATA_W),
    localparam int CODE_W = BIT_W + evt_irq_pkg::GRP_FIELD_W,
    localparam int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [CODE_W-1:0] evt_code,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_a,
    output logic              irq_b,
    output logic              irq_c
);

    import evt_irq_pkg::*;

    localparam int LINES = IRQ_LINES;

    logic [GROUPS-1:0][DATA_W-1:0]             set_vec;
    logic [GROUPS-1:0][DATA_W-1:0]             pend_q;
    logic [LINES-1:0][GROUPS-1:0][DATA_W-1:0]  mask_q;
    logic [LINES-1:0]                          irq_vec;

    bank_e      bank_sel;
    logic [1:0] grp_sel;
    logic       grp_ok;

    assign bank_sel = bank_e'(reg_addr[3:2]);
    assign grp_sel  = reg_addr[1:0];
    assign grp_ok   = int'(grp_sel) < GROUPS;

    evt_code_decode #(
        .GROUPS (GROUPS),
        .DATA_W (DATA_W)
    ) u_decode (
        .evt_valid (evt_valid),
        .evt_code  (evt_code),
        .set_vec   (set_vec)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic clr_hit;
        assign clr_hit = reg_wr && (bank_sel == BANK_PEND) && (int'(grp_sel) == g);

        evt_pend_word #(
            .DATA_W (DATA_W)
        ) u_pend (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_bits (set_vec[g]),
            .clr_en   (clr_hit),
            .clr_bits (reg_wdata),
            .pend     (pend_q[g])
        );

        for (genvar l = 0; l < LINES; l++) begin : g_mask
            logic wr_hit;
            assign wr_hit = reg_wr && (int'(bank_sel) == l + 1) && (int'(grp_sel) == g);

            evt_mask_word #(
                .DATA_W (DATA_W)
            ) u_mask (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (wr_hit),
                .wdata (reg_wdata),
                .mask  (mask_q[l][g])
            );
        end
    end

    evt_irq_reduce #(
        .GROUPS (GROUPS),
        .DATA_W (DATA_W),
        .LINES  (LINES)
    ) u_reduce (
        .pend  (pend_q),
        .masks (mask_q),
        .irq   (irq_vec)
    );

    // Readback mux; group slot 3 of every bank reads as zero.
    always_comb begin
        reg_rdata = '0;
        if (grp_ok) begin
            unique case (bank_sel)
                BANK_PEND:   reg_rdata = pend_q[grp_sel];
                BANK_MASK_A: reg_rdata = mask_q[0][grp_sel];
                BANK_MASK_B: reg_rdata = mask_q[1][grp_sel];
                BANK_MASK_C: reg_rdata = mask_q[2][grp_sel];
            endcase
        end
    end

    assign irq_a = irq_vec[0];
    assign irq_b = irq_vec[1];
    assign irq_c = irq_vec[2];

endmodule

// File: rtl/evt_irq_hub_chk.sv
module evt_irq_hub_chk #(
    parameter int GROUPS = 3,
    parameter int DATA_W = 32,
    parameter int CODE_W = 7
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          evt_valid,
    input logic [CODE_W-1:0]             evt_code,
    input logic                          reg_wr,
    input logic [3:0]                    reg_addr,
    input logic [DATA_W-1:0]             reg_wdata,
    input logic [GROUPS-1:0][DATA_W-1:0] pend,
    input logic                          irq_a,
    input logic                          irq_b,
    input logic                          irq_c
);

    localparam int BIT_W = CODE_W - 2;

    logic [1:0]       c_grp;
    logic [BIT_W-1:0] c_bit;
    logic             c_grp_ok;
    logic             pend_wr;

    assign c_grp    = evt_code[CODE_W-1 -: 2];
    assign c_bit    = evt_code[BIT_W-1:0];
    assign c_grp_ok = int'(c_grp) < GROUPS;
    assign pend_wr  = reg_wr && (reg_addr[3:2] == 2'd0) && (int'(reg_addr[1:0]) < GROUPS);

    // R1 together with R4: a valid event always lands, even against a clear.
    assert_event_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && c_grp_ok) |=> pend[$past(c_grp)][$past(c_bit)]);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_valid && !reg_wr) |=> $stable(pend));

    assert_w1c_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_wr && !evt_valid) |=> ((pend[$past(reg_addr[1:0])] & $past(reg_wdata)) == '0));

    assert_grp3_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (c_grp == 2'd3) && !reg_wr) |=> $stable(pend));

    assert_quiet_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (!irq_a && !irq_b && !irq_c));

    assert_mask_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == 4'd4) && ((reg_wdata & pend[0]) != '0)) |=> irq_a);

endmodule

bind evt_irq_hub evt_irq_hub_chk #(
    .GROUPS (GROUPS),
    .DATA_W (DATA_W),
    .CODE_W (CODE_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pend      (pend_q),
    .irq_a     (irq_a),
    .irq_b     (irq_b),
    .irq_c     (irq_c)
);

// File: tb/evt_irq_hub_tb_top.sv
`timescale 1ns/100ps
module evt_irq_hub_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [6:0]  evt_code = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_a, irq_b, irq_c;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    evt_irq_hub dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_code  (evt_code),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_a     (irq_a),
        .irq_b     (irq_b),
        .irq_c     (irq_c)
    );

    // op: 0 = event (a = code), 1 = write (a[3:0] = offset), 2 = read and check
    typedef struct packed {
        logic [1:0]  op;
        logic [6:0]  a;
        logic [31:0] d;
        logic [31:0] exp;
        logic [2:0]  irq;   // {a, b, c}
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 26;
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 7'h03, 32'h0,        32'h0,        3'b000, 4'd1},  // R1 g0 b3
        '{2'd2, 7'h00, 32'h0,        32'h8,        3'b000, 4'd1},
        '{2'd0, 7'h25, 32'h0,        32'h0,        3'b000, 4'd1},  // R1 g1 b5
        '{2'd2, 7'h01, 32'h0,        32'h20,       3'b000, 4'd1},
        '{2'd0, 7'h5F, 32'h0,        32'h0,        3'b000, 4'd1},  // R1 g2 b31
        '{2'd2, 7'h02, 32'h0,        32'h80000000, 3'b000, 4'd1},
        '{2'd1, 7'h04, 32'h8,        32'h0,        3'b000, 4'd6},  // R6 A mask g0
        '{2'd2, 7'h04, 32'h0,        32'h8,        3'b100, 4'd7},  // R7
        '{2'd1, 7'h09, 32'h20,       32'h0,        3'b000, 4'd6},  // R6 B mask g1
        '{2'd2, 7'h09, 32'h0,        32'h20,       3'b110, 4'd7},
        '{2'd1, 7'h0E, 32'h80000000, 32'h0,        3'b000, 4'd6},  // R6 C mask g2
        '{2'd2, 7'h0E, 32'h0,        32'h80000000, 3'b111, 4'd7},
        '{2'd1, 7'h00, 32'h0,        32'h0,        3'b000, 4'd3},  // R3 zero write
        '{2'd2, 7'h00, 32'h0,        32'h8,        3'b111, 4'd3},
        '{2'd1, 7'h00, 32'h8,        32'h0,        3'b000, 4'd3},  // R3 clear b3
        '{2'd2, 7'h00, 32'h0,        32'h0,        3'b011, 4'd8},  // R8
        '{2'd1, 7'h0E, 32'h0,        32'h0,        3'b000, 4'd8},  // R8 C off
        '{2'd2, 7'h0E, 32'h0,        32'h0,        3'b010, 4'd8},
        '{2'd1, 7'h05, 32'hFFFFFFFF, 32'h0,        3'b000, 4'd6},  // R6 A mask g1
        '{2'd2, 7'h05, 32'h0,        32'hFFFFFFFF, 3'b110, 4'd7},
        '{2'd1, 7'h01, 32'hFFFFFFFF, 32'h0,        3'b000, 4'd3},  // R3 clear g1
        '{2'd2, 7'h01, 32'h0,        32'h0,        3'b000, 4'd8},
        '{2'd2, 7'h02, 32'h0,        32'h80000000, 3'b000, 4'd2},  // R2 sticky
        '{2'd1, 7'h03, 32'h1234,     32'h0,        3'b000, 4'd9},  // R9
        '{2'd2, 7'h03, 32'h0,        32'h0,        3'b000, 4'd9},
        '{2'd2, 7'h08, 32'h0,        32'h0,        3'b000, 4'd6}   // R6 unwritten
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_event(input logic [6:0] code);
        @(negedge clk);
        evt_valid = 1'b1;
        evt_code  = code;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic do_write(input logic [3:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = addr;
        reg_wdata = data;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic do_read(input int req, input logic [3:0] addr,
                           input logic [31:0] exp, input logic [2:0] irq_exp);
        @(negedge clk);
        reg_addr = addr;
        #1;
        check(req, $sformatf("rdata @%0d", addr), reg_rdata, exp);
        check(req, $sformatf("irq abc @%0d", addr), {29'd0, irq_a, irq_b, irq_c}, {29'd0, irq_exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: state while reset is held
        repeat (3) @(negedge clk);
        reg_addr = 4'd0;
        #1;
        check(10, "pend0 in reset", reg_rdata, 32'h0);
        check(10, "irq in reset", {29'd0, irq_a, irq_b, irq_c}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            unique case (VEC[i].op)
                2'd0: do_event(VEC[i].a);
                2'd1: do_write(VEC[i].a[3:0], VEC[i].d);
                default: do_read(int'(VEC[i].req), VEC[i].a[3:0], VEC[i].exp, VEC[i].irq);
            endcase
        end

        // R4: event and clear on the same bit in one cycle
        do_event(7'h2A);
        do_read(1, 4'd1, 32'h400, 3'b100);
        @(negedge clk);
        evt_valid = 1'b1;
        evt_code  = 7'h2A;
        reg_wr    = 1'b1;
        reg_addr  = 4'd1;
        reg_wdata = 32'h400;
        @(negedge clk);
        evt_valid = 1'b0;
        reg_wr    = 1'b0;
        do_read(4, 4'd1, 32'h400, 3'b100);

        // R5: group field 3 is dropped
        do_event(7'h63);
        do_event(7'h7F);
        do_read(5, 4'd0, 32'h0, 3'b100);
        do_read(5, 4'd1, 32'h400, 3'b100);
        do_read(5, 4'd2, 32'h80000000, 3'b100);

        // R3: clear of the collided bit now works
        do_write(4'd1, 32'h400);
        do_read(3, 4'd1, 32'h0, 3'b000);

        // R10: reset in mid-run wipes every mapped word
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int off = 0; off < 15; off++) begin
            if ((off % 4) != 3) do_read(10, 4'(off), 32'h0, 3'b000);
        end

        // R9: writes to unmapped slots touch nothing
        do_write(4'd7,  32'hFFFFFFFF);
        do_write(4'd11, 32'hFFFFFFFF);
        do_write(4'd15, 32'hFFFFFFFF);
        do_event(7'h00);
        for (int off = 4; off < 16; off++) begin
            do_read(9, 4'(off), 32'h0, 3'b000);
        end
        do_read(9, 4'd0, 32'h1, 3'b000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule